// File: doc/BRIEF.md
# Integer to Floating-Point Converter

This block turns a 32-bit or 64-bit integer into an IEEE 754 binary floating-point number. The integer can be read as signed or as unsigned. The result can be single or double precision. A single-precision result comes out in the 64-bit double-precision layout, but its value is already rounded to single precision. The caller selects the source width, the signedness, the destination precision and one of four rounding modes on each operation.

Each accepted operand gives one registered result on the next clock edge. The result comes with a class code for the status register, a flag that reports an increment of the significand during rounding, an inexact flag and a write-enable for those status fields. A 32-bit integer always fits in a double exactly. That one combination therefore drops the write-enable, and the status fields are left as they were. Every other combination rounds and raises the write-enable.

Top module: `int2fp_conv`

## Requirements
- R1: `out_valid` is high exactly one clock after a cycle with `in_valid` high, and low one clock after a cycle with `in_valid` low.
- R2: A 32-bit source (`in_wide`=0) converted to double (`in_double`=1) produces the exact value, with `out_status_we`=0 and `out_class`, `out_frac_rnd` and `out_inexact` all 0.
- R3: Every other combination of source width and precision produces `out_status_we`=1.
- R4: The rounding-mode encodings are 00 nearest with ties to even, 01 toward zero, 10 toward +infinity and 11 toward -infinity.
- R5: A single-precision result uses the double layout: sign in bit 63, exponent biased by 1023 in bits 62:52, and the 23 fraction bits in bits 51:29. Bits 28:0 are zero.
- R6: When `out_status_we`=1, `out_class` is 00010 for +0, 00100 for a positive normal value and 10000 for a negative normal value.
- R7: `out_frac_rnd` is 1 exactly when rounding incremented the significand.
- R8: `out_inexact` is 1 exactly when the rounded result differs from the integer value.
- R9: A zero operand produces +0.0, meaning all 64 result bits are zero.
- R10: An unsigned operand treats its top bit as magnitude and always gives sign 0. A signed operand is negated by two's complement to get its magnitude, and its sign goes to bit 63.
- R11: While `rst` is high, `out_valid` and `out_status_we` are 0 on the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present this cycle |
| in_operand | input | 64 | Integer operand; only bits 31:0 are used for a 32-bit source |
| in_signed | input | 1 | 1 = signed, 0 = unsigned |
| in_wide | input | 1 | 1 = 64-bit source, 0 = 32-bit source |
| in_double | input | 1 | 1 = double result, 0 = single result |
| in_rmode | input | 2 | Rounding mode (00 nearest-even, 01 zero, 10 +inf, 11 -inf) |
| out_valid | output | 1 | Result present |
| out_result | output | 64 | Result in double-precision layout |
| out_class | output | 5 | Result class code |
| out_frac_rnd | output | 1 | Significand was incremented |
| out_inexact | output | 1 | Conversion was inexact |
| out_status_we | output | 1 | Status fields should be written |

## Verification
The bench drives zero, plus and minus one, and the most negative signed value. These show the sign and class handling and the two's-complement magnitude path. All-ones unsigned operands carry through rounding into the next exponent, which separates a correct exponent bump from a wrapped fraction. Operands sitting exactly halfway between two neighbours, with odd and with even kept bits, separate ties-to-even from round-half-up. The same values are driven under the directed modes with both signs, so a swapped +inf/-inf encoding shows up. Exact 32-bit-to-double and 32-bit-to-single cases separate the quiet path from the rounding paths, and a long run of random operands over all mode combinations follows.

// File: rtl/i2f_pkg.sv
package i2f_pkg;
  localparam logic [1:0] RM_NEAR = 2'b00;
  localparam logic [1:0] RM_ZERO = 2'b01;
  localparam logic [1:0] RM_PINF = 2'b10;
  localparam logic [1:0] RM_NINF = 2'b11;

  localparam int CLS_W = 5;
  localparam logic [CLS_W-1:0] CLS_NONE  = 5'b00000;
  localparam logic [CLS_W-1:0] CLS_PZERO = 5'b00010;
  localparam logic [CLS_W-1:0] CLS_PNORM = 5'b00100;
  localparam logic [CLS_W-1:0] CLS_NNORM = 5'b10000;
endpackage

// File: rtl/i2f_operand.sv
// Source width selection and sign/magnitude split.
module i2f_operand #(
  parameter int INT_W = 64
) (
  input  logic [INT_W-1:0] operand,
  input  logic             is_signed,
  input  logic             wide,
  output logic [INT_W-1:0] mag,
  output logic             neg
);
  localparam int HALF = INT_W / 2;

  logic [INT_W-1:0] ext;

  always_comb begin
    if (wide) ext = operand;
    else      ext = {{HALF{is_signed & operand[HALF-1]}}, operand[HALF-1:0]};
    neg = is_signed & ext[INT_W-1];
    mag = neg ? (~ext + INT_W'(1)) : ext;
  end
endmodule

// File: rtl/i2f_normalize.sv
// Leading-one detection and left shift so the leading one lands in the top bit.
module i2f_normalize #(
  parameter int INT_W = 64,
  localparam int LZ_W = $clog2(INT_W)
) (
  input  logic [INT_W-1:0] mag,
  output logic [INT_W-2:0] below,
  output logic [LZ_W-1:0]  lz,
  output logic             is_zero
);
  logic [INT_W-1:0] shifted;

  always_comb begin
    lz = '0;
    for (int i = 0; i < INT_W; i++) begin
      if (mag[i]) lz = LZ_W'(INT_W - 1 - i);
    end
    shifted = mag << lz;
    is_zero = ~shifted[INT_W-1];
    below   = shifted[INT_W-2:0];
  end
endmodule

// File: rtl/i2f_round.sv
// Rounds the bits below the hidden one to F fraction bits.
module i2f_round #(
  parameter int IN_W = 63,
  parameter int F    = 52
) (
  input  logic [IN_W-1:0] bits_in,
  input  logic            neg,
  input  logic [1:0]      rmode,
  output logic [F-1:0]    frac,
  output logic            carry,
  output logic            inc,
  output logic            inexact
);
  import i2f_pkg::*;
  localparam int RB = IN_W - F;

  logic [F-1:0] kept;
  logic         guard, sticky;

  always_comb begin
    kept    = bits_in[IN_W-1 -: F];
    guard   = bits_in[RB-1];
    sticky  = |bits_in[RB-2:0];
    inexact = guard | sticky;
    case (rmode)
      RM_NEAR: inc = guard & (sticky | kept[0]);
      RM_ZERO: inc = 1'b0;
      RM_PINF: inc = inexact & ~neg;
      default: inc = inexact & neg;
    endcase
    frac  = kept + F'(inc);
    carry = inc & (&kept);
  end
endmodule

// File: rtl/int2fp_conv.sv
module int2fp_conv #(
  parameter int INT_W   = 64,
  parameter int DEXP_W  = 11,
  parameter int DFRAC_W = 52,
  parameter int SFRAC_W = 23,
  localparam int RES_W  = 1 + DEXP_W + DFRAC_W,
  localparam int LZ_W   = $clog2(INT_W),
  localparam int BIAS   = (1 << (DEXP_W - 1)) - 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [INT_W-1:0]     in_operand,
  input  logic                 in_signed,
  input  logic                 in_wide,
  input  logic                 in_double,
  input  logic [1:0]           in_rmode,
  output logic                 out_valid,
  output logic [RES_W-1:0]     out_result,
  output logic [4:0]           out_class,
  output logic                 out_frac_rnd,
  output logic                 out_inexact,
  output logic                 out_status_we
);
  import i2f_pkg::*;

  logic [INT_W-1:0] mag;
  logic             neg;
  logic [INT_W-2:0] below;
  logic [LZ_W-1:0]  lz;
  logic             is_zero;

  i2f_operand #(.INT_W(INT_W)) u_operand (
    .operand(in_operand), .is_signed(in_signed), .wide(in_wide),
    .mag(mag), .neg(neg)
  );

  i2f_normalize #(.INT_W(INT_W)) u_norm (
    .mag(mag), .below(below), .lz(lz), .is_zero(is_zero)
  );

  // Index 0 = single precision, index 1 = double precision.
  logic [DFRAC_W-1:0] frac_p  [2];
  logic               carry_p [2];
  logic               inc_p   [2];
  logic               inex_p  [2];

  for (genvar g = 0; g < 2; g++) begin : g_prec
    localparam int FW = (g == 1) ? DFRAC_W : SFRAC_W;
    logic [FW-1:0] rfrac;
    i2f_round #(.IN_W(INT_W - 1), .F(FW)) u_round (
      .bits_in(below), .neg(neg), .rmode(in_rmode),
      .frac(rfrac), .carry(carry_p[g]), .inc(inc_p[g]), .inexact(inex_p[g])
    );
    assign frac_p[g] = DFRAC_W'(rfrac) << (DFRAC_W - FW);
  end

  logic               sel;
  logic               quiet;
  logic [DEXP_W-1:0]  exp_b;
  logic [RES_W-1:0]   res_c;
  logic [4:0]         cls_c;
  logic               fr_c, xx_c;

  always_comb begin
    sel   = in_double;
    quiet = ~in_wide & in_double;
    exp_b = DEXP_W'(BIAS + INT_W - 1) - DEXP_W'(lz) + DEXP_W'(carry_p[sel]);
    if (is_zero) begin
      res_c = '0;
      cls_c = CLS_PZERO;
      fr_c  = 1'b0;
      xx_c  = 1'b0;
    end else begin
      res_c = {neg, exp_b, frac_p[sel]};
      cls_c = neg ? CLS_NNORM : CLS_PNORM;
      fr_c  = inc_p[sel];
      xx_c  = inex_p[sel];
    end
    if (quiet) begin
      cls_c = CLS_NONE;
      fr_c  = 1'b0;
      xx_c  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_status_we <= 1'b0;
      out_result    <= '0;
      out_class     <= CLS_NONE;
      out_frac_rnd  <= 1'b0;
      out_inexact   <= 1'b0;
    end else begin
      out_valid     <= in_valid;
      out_status_we <= in_valid & ~quiet;
      if (in_valid) begin
        out_result   <= res_c;
        out_class    <= cls_c;
        out_frac_rnd <= fr_c;
        out_inexact  <= xx_c;
      end
    end
  end

  // Checks on the registered stage.
  assert_one_cycle_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_quiet_path_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_wide && in_double) |=> (!out_status_we && !out_frac_rnd && !out_inexact));

  assert_rz_no_increment_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_rmode == RM_ZERO) |=> !out_frac_rnd);

  assert_class_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $onehot0(out_class));

  assert_increment_inexact_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_frac_rnd) |-> out_inexact);

  assert_zero_result_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (in_wide ? (in_operand == '0) : (in_operand[INT_W/2-1:0] == '0)))
      |=> (out_result == '0));

  assert_unsigned_sign_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_signed) |=> !out_result[RES_W-1]);
endmodule

// File: tb/int2fp_conv_tb.sv
`timescale 1ns/1ps
module int2fp_conv_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] in_operand = '0;
  logic        in_signed = 1'b0, in_wide = 1'b0, in_double = 1'b0;
  logic [1:0]  in_rmode = 2'b00;
  logic        out_valid, out_frac_rnd, out_inexact, out_status_we;
  logic [63:0] out_result;
  logic [4:0]  out_class;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  int2fp_conv u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_operand(in_operand),
    .in_signed(in_signed), .in_wide(in_wide), .in_double(in_double),
    .in_rmode(in_rmode), .out_valid(out_valid), .out_result(out_result),
    .out_class(out_class), .out_frac_rnd(out_frac_rnd),
    .out_inexact(out_inexact), .out_status_we(out_status_we)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Behavioural model: right-shift the magnitude and inspect the remainder.
  function automatic void model(input logic [63:0] op, input logic sg, wd, dp,
                                input logic [1:0] rm, output logic [63:0] res,
                                output logic [4:0] cls, output logic fr, xx, we);
    logic [63:0] x, mag, sig, rem, half;
    logic neg, inc;
    int p, f, sh;
    if (wd) x = op;
    else    x = sg ? {{32{op[31]}}, op[31:0]} : {32'b0, op[31:0]};
    neg = sg && x[63];
    mag = neg ? (~x + 64'd1) : x;
    we  = !(!wd && dp);
    f   = dp ? 52 : 23;
    inc = 1'b0;
    xx  = 1'b0;
    if (mag == 0) begin
      res = '0;
      cls = 5'b00010;
    end else begin
      p = 0;
      for (int i = 0; i < 64; i++) if (mag[i]) p = i;
      if (p <= f) begin
        sig = mag << (f - p);
      end else begin
        sh   = p - f;
        sig  = mag >> sh;
        rem  = mag & ((64'd1 << sh) - 64'd1);
        half = 64'd1 << (sh - 1);
        xx   = (rem != 0);
        case (rm)
          2'b00: inc = (rem > half) || (rem == half && sig[0]);
          2'b01: inc = 1'b0;
          2'b10: inc = xx && !neg;
          default: inc = xx && neg;
        endcase
        sig = sig + {63'd0, inc};
        if (sig == (64'd1 << (f + 1))) begin
          sig = sig >> 1;
          p++;
        end
      end
      res = {neg, 11'(p + 1023), 52'((sig & ((64'd1 << f) - 64'd1)) << (52 - f))};
      cls = neg ? 5'b10000 : 5'b00100;
    end
    fr = inc;
    if (!we) begin
      cls = 5'b00000;
      fr  = 1'b0;
      xx  = 1'b0;
    end
  endfunction

  // Called at a falling edge; checks the outputs at the next falling edge.
  task automatic step(input logic [63:0] op, input logic sg, wd, dp,
                      input logic [1:0] rm, input string tag);
    logic [63:0] e_res;
    logic [4:0]  e_cls;
    logic        e_fr, e_xx, e_we;
    model(op, sg, wd, dp, rm, e_res, e_cls, e_fr, e_xx, e_we);
    in_valid = 1'b1; in_operand = op; in_signed = sg;
    in_wide = wd; in_double = dp; in_rmode = rm;
    @(negedge clk);
    chk("R1", "valid", {63'd0, out_valid}, 64'd1);
    chk(tag, "result", out_result, e_res);
    chk("R6", "class", {59'd0, out_class}, {59'd0, e_cls});
    chk("R7", "frac_rnd", {63'd0, out_frac_rnd}, {63'd0, e_fr});
    chk("R8", "inexact", {63'd0, out_inexact}, {63'd0, e_xx});
    chk(e_we ? "R3" : "R2", "status_we", {63'd0, out_status_we}, {63'd0, e_we});
    if (!dp) chk("R5", "single low bits", {35'd0, out_result[28:0]}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11", "valid in reset", {63'd0, out_valid}, 64'd0);
    chk("R11", "we in reset", {63'd0, out_status_we}, 64'd0);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    chk("R1", "idle valid", {63'd0, out_valid}, 64'd0);

    // R9 zero operands
    step(64'd0, 1'b1, 1'b1, 1'b1, 2'b00, "R9");
    step(64'hFFFF_FFFF_0000_0000, 1'b1, 1'b0, 1'b0, 2'b10, "R9");
    // R10 signs and magnitudes
    step(64'd1, 1'b0, 1'b1, 1'b1, 2'b00, "R10");
    step(64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 1'b1, 2'b00, "R10");
    step(64'h8000_0000_0000_0000, 1'b1, 1'b1, 1'b1, 2'b00, "R10");
    step(64'h8000_0000_0000_0000, 1'b0, 1'b1, 1'b1, 2'b00, "R10");
    step(64'h0000_0000_8000_0000, 1'b1, 1'b0, 1'b1, 2'b00, "R10");
    // R2 exact 32-bit to double
    step(64'h0000_0000_FFFF_FFFF, 1'b0, 1'b0, 1'b1, 2'b10, "R2");
    step(64'h0000_0000_7FFF_FFFF, 1'b1, 1'b0, 1'b1, 2'b11, "R2");
    // R4 carry into next exponent, all modes
    for (int m = 0; m < 4; m++)
      step(64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b1, 1'b1, 2'(m), "R4");
    // R4 ties: even kept bit stays, odd kept bit rounds up
    step(64'h0020_0000_0000_0001, 1'b0, 1'b1, 1'b1, 2'b00, "R4");
    step(64'h0020_0000_0000_0003, 1'b0, 1'b1, 1'b1, 2'b00, "R4");
    step(64'h0000_0000_0100_0001, 1'b0, 1'b0, 1'b0, 2'b00, "R4");
    step(64'h0000_0000_0100_0003, 1'b0, 1'b0, 1'b0, 2'b00, "R4");
    // R4 directed modes with both signs
    for (int m = 0; m < 4; m++) begin
      step(64'h0000_0000_0100_0001, 1'b1, 1'b0, 1'b0, 2'(m), "R4");
      step(64'h0000_0000_FEFF_FFFF, 1'b1, 1'b0, 1'b0, 2'(m), "R4");
    end
    // R5 single precision from 64-bit source
    step(64'h0123_4567_89AB_CDEF, 1'b0, 1'b1, 1'b0, 2'b00, "R5");
    step(64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b1, 1'b0, 2'b10, "R5");
    // Random sweep
    for (int k = 0; k < 600; k++) begin
      logic [63:0] r;
      r = {$urandom, $urandom};
      if (k % 3 == 1) r = r >> ($urandom % 64);
      step(r, 1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom), "R4");
    end
    in_valid = 1'b0;
    @(negedge clk);
    chk("R1", "valid after stream", {63'd0, out_valid}, 64'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule